// File: doc/BRIEF.md
# Dual-Key Register Write Guard

This block sits between a 32-bit register bus and a peripheral's configuration registers and stops stray or runaway writes from reaching them. Software arms the guard by writing two distinct 32-bit magic words into two key slots. Only while both slots hold their magic word does the block raise the write-enable qualifier that the protected register file uses to accept a write. Reads always pass.

Writing anything other than the magic word into a key slot disarms the guard, and zero is the normal value for this. Reading a key slot never returns the key. It returns a single status bit that shows whether the guard is open. A three-word scratch area inside the block uses the qualifier itself, so the effect of the guard can be seen through ordinary reads.

Top module: `key_unlock_guard`

## Requirements
- R1: After reset the guard is closed: `unlocked` is 0, key slots read 0 and every scratch word reads 0.
- R2: The guard opens on the clock edge that completes the pair: key slot A (address 0x6C) holding 0x83E70B13 and key slot B (address 0x70) holding 0x95A4F1E0. The two keys may be written in either order, and `unlocked` reads 1 from the next cycle on.
- R3: While only one key slot holds its magic word, the guard stays closed.
- R4: A write of any value other than its own magic word to either key slot clears that slot. The guard is closed from the next cycle.
- R5: Writing 0 to both key slots closes the guard.
- R6: While the guard is closed, a bus write to any non-key address leaves `prot_wr_en` low and changes no scratch word. No error is reported.
- R7: While the guard is open, a bus write to any non-key address raises `prot_wr_en` in that same cycle. A write to a scratch word (0x60, 0x64, 0x68) takes effect at the next clock edge.
- R8: Scratch words can be read in the same cycle as the read request whether the guard is open or closed. Other non-key addresses read 0.
- R9: A read of either key slot returns 1 in bit 0 when the guard is open and 0 when closed, with bits 31:1 zero. The key value is never returned.
- R10: A write to a key slot never raises `prot_wr_en`.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_rd | input | 1 | Read strobe for the current bus cycle |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| prot_wr_en | output | 1 | Qualified write enable for the protected registers |
| unlocked | output | 1 | Guard open (both keys hold their magic words) |

## Verification
Directed sequences open the guard with the keys written in both orders. They also try a single correct key, a wrong value in an armed slot, and the zero-write relock, so that a design which checks only one key, or which treats any non-zero value as a key, stands apart from a correct one. Scratch writes are attempted while the guard is closed and while it is open, and then read back. A dropped write, a leaked write and a lost write each give a different readback. Random traffic over the key, scratch and unrelated addresses follows, with key data biased toward the magic words, zero and random values. Each write's qualifier and each read's data are compared against a bench model of the two key flags and the scratch contents.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int SCR_WORDS  = 3;
    localparam int SCR_IDX_W  = (SCR_WORDS > 1) ? $clog2(SCR_WORDS) : 1;
    localparam int WORD_BYTES = DATA_W / 8;

    localparam logic [ADDR_W-1:0] KEY_A_ADDR = 8'h6C;
    localparam logic [ADDR_W-1:0] KEY_B_ADDR = 8'h70;
    localparam logic [ADDR_W-1:0] SCR_BASE   = 8'h60;

    localparam logic [DATA_W-1:0] KEY_A_MAGIC = 32'h83E7_0B13;
    localparam logic [DATA_W-1:0] KEY_B_MAGIC = 32'h95A4_F1E0;

    typedef enum logic [1:0] {
        SLOT_KEY_A   = 2'd0,
        SLOT_KEY_B   = 2'd1,
        SLOT_SCRATCH = 2'd2,
        SLOT_OTHER   = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e           kind;
        logic [SCR_IDX_W-1:0] index;
    } slot_t;

    function automatic slot_t decode_slot(input logic [ADDR_W-1:0] a);
        slot_t s;
        s.kind  = SLOT_OTHER;
        s.index = '0;
        if (a == KEY_A_ADDR) begin
            s.kind = SLOT_KEY_A;
        end else if (a == KEY_B_ADDR) begin
            s.kind = SLOT_KEY_B;
        end else begin
            for (int i = 0; i < SCR_WORDS; i++) begin
                if (a == SCR_BASE + ADDR_W'(i * WORD_BYTES)) begin
                    s.kind  = SLOT_SCRATCH;
                    s.index = SCR_IDX_W'(i);
                end
            end
        end
        return s;
    endfunction

    function automatic logic is_key_slot(input slot_kind_e k);
        return (k == SLOT_KEY_A) || (k == SLOT_KEY_B);
    endfunction
endpackage

// File: rtl/guard_key_bank.sv
module guard_key_bank
    import guard_pkg::*;
#(
    parameter int                NKEYS   = 2,
    parameter logic [DATA_W-1:0] MAGIC_A = KEY_A_MAGIC,
    parameter logic [DATA_W-1:0] MAGIC_B = KEY_B_MAGIC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NKEYS-1:0]  key_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              open
);
    localparam logic [NKEYS-1:0][DATA_W-1:0] MAGIC = {MAGIC_B, MAGIC_A};

    // one match flag per slot instead of the full key word
    logic [NKEYS-1:0] match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
        end else begin
            for (int k = 0; k < NKEYS; k++) begin
                if (key_wr[k]) begin
                    match_q[k] <= (wdata == MAGIC[k]);
                end
            end
        end
    end

    assign open = &match_q;
endmodule

// File: rtl/guard_scratch_bank.sv
module guard_scratch_bank
    import guard_pkg::*;
#(
    parameter int WORDS = SCR_WORDS,
    parameter int IDX_W = SCR_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (we && (idx == IDX_W'(w))) begin
                word_q <= wdata;
            end
        end
        assign words[w] = word_q;
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (idx == IDX_W'(w)) rdata = words[w];
        end
    end
endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
    import guard_pkg::*;
#(
    parameter logic [DATA_W-1:0] MAGIC_A = KEY_A_MAGIC,
    parameter logic [DATA_W-1:0] MAGIC_B = KEY_B_MAGIC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prot_wr_en,
    output logic              unlocked
);
    slot_t             slot;
    logic [1:0]        key_wr;
    logic              guard_open;
    logic [DATA_W-1:0] scr_rdata;

    assign slot = decode_slot(bus_addr);

    assign key_wr[0] = bus_wr && (slot.kind == SLOT_KEY_A);
    assign key_wr[1] = bus_wr && (slot.kind == SLOT_KEY_B);

    guard_key_bank #(
        .NKEYS  (2),
        .MAGIC_A(MAGIC_A),
        .MAGIC_B(MAGIC_B)
    ) u_keys (
        .clk   (clk),
        .rst   (rst),
        .key_wr(key_wr),
        .wdata (bus_wdata),
        .open  (guard_open)
    );

    assign prot_wr_en = bus_wr && guard_open && !is_key_slot(slot.kind);
    assign unlocked   = guard_open;

    guard_scratch_bank #(
        .WORDS(SCR_WORDS),
        .IDX_W(SCR_IDX_W)
    ) u_scratch (
        .clk  (clk),
        .rst  (rst),
        .we   (prot_wr_en && (slot.kind == SLOT_SCRATCH)),
        .idx  (slot.index),
        .wdata(bus_wdata),
        .rdata(scr_rdata)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (slot.kind)
                SLOT_KEY_A, SLOT_KEY_B: bus_rdata = DATA_W'(guard_open);
                SLOT_SCRATCH:           bus_rdata = scr_rdata;
                default:                bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/key_guard_checker.sv
module key_guard_checker
    import guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              prot_wr_en,
    input logic              unlocked
);
    logic key_addr;
    assign key_addr = (bus_addr == KEY_A_ADDR) || (bus_addr == KEY_B_ADDR);

    assert_closed_after_reset_R1: assert property (@(posedge clk)
        rst |=> !unlocked);

    assert_open_needs_key_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(bus_wr && ((bus_addr == KEY_A_ADDR && bus_wdata == KEY_A_MAGIC) ||
                                             (bus_addr == KEY_B_ADDR && bus_wdata == KEY_B_MAGIC))));

    assert_wrong_key_closes_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ((bus_addr == KEY_A_ADDR && bus_wdata != KEY_A_MAGIC) ||
                    (bus_addr == KEY_B_ADDR && bus_wdata != KEY_B_MAGIC))) |=> !unlocked);

    assert_closed_drops_R6: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !prot_wr_en);

    assert_open_passes_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && unlocked && !key_addr) |-> prot_wr_en);

    assert_key_read_status_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && key_addr) |-> (bus_rdata == DATA_W'(unlocked)));

    assert_key_write_unqualified_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && key_addr) |-> !prot_wr_en);

    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind key_unlock_guard key_guard_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .prot_wr_en(prot_wr_en),
    .unlocked  (unlocked)
);

// File: tb/key_unlock_guard_tb.sv
module key_unlock_guard_tb;
    import guard_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              prot_wr_en;
    logic              unlocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    bit                m_a = 1'b0;
    bit                m_b = 1'b0;
    logic [DATA_W-1:0] m_scr [SCR_WORDS];

    always #10 clk = ~clk;

    key_unlock_guard u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .prot_wr_en(prot_wr_en),
        .unlocked  (unlocked)
    );

    function automatic bit is_key(input logic [ADDR_W-1:0] a);
        return (a == 8'h6C) || (a == 8'h70);
    endfunction

    function automatic int scr_index(input logic [ADDR_W-1:0] a);
        if (a == 8'h60) return 0;
        if (a == 8'h64) return 1;
        if (a == 8'h68) return 2;
        return -1;
    endfunction

    function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
        if (is_key(a)) return DATA_W'(m_a && m_b);
        if (scr_index(a) >= 0) return m_scr[scr_index(a)];
        return '0;
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        check(tag, DATA_W'(prot_wr_en), DATA_W'(m_a && m_b && !is_key(a)));
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        if (a == 8'h6C) m_a = (d == 32'h83E7_0B13);
        else if (a == 8'h70) m_b = (d == 32'h95A4_F1E0);
        else if (scr_index(a) >= 0 && prot_wr_en_model_prev) m_scr[scr_index(a)] = d;
    endtask

    // open state sampled before the write updates the model
    bit prot_wr_en_model_prev;
    always @(negedge clk) prot_wr_en_model_prev = m_a && m_b;

    task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
    endtask

    task automatic check_open(input string tag);
        @(negedge clk);
        #1;
        check(tag, DATA_W'(unlocked), DATA_W'(m_a && m_b));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [ADDR_W-1:0] pool [6];
        void'($urandom(32'd20240611));
        pool[0] = 8'h60; pool[1] = 8'h64; pool[2] = 8'h68;
        pool[3] = 8'h6C; pool[4] = 8'h70; pool[5] = 8'h40;
        for (int i = 0; i < SCR_WORDS; i++) m_scr[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check_open("R1 unlocked after reset");
        do_read(8'h6C, "R1 key A read after reset");
        do_read(8'h64, "R1 scratch read after reset");
        do_read(8'h40, "R8 unrelated address reads zero");
        @(negedge clk); #1;
        check("R11 no read gives zero", bus_rdata, '0);

        // R6 write while closed is dropped
        do_write(8'h60, 32'hDEAD_BEEF, "R6 closed scratch write qualifier");
        do_read(8'h60, "R6 R8 closed scratch readback");

        // R3 only one key correct
        do_write(8'h6C, 32'h83E7_0B13, "R10 key A write qualifier");
        check_open("R3 single key keeps closed");
        do_write(8'h68, 32'h1234_5678, "R3 one-key write dropped");
        do_read(8'h68, "R3 one-key scratch readback");

        // R2 second key opens
        do_write(8'h70, 32'h95A4_F1E0, "R10 key B write qualifier");
        check_open("R2 open after A then B");
        do_read(8'h6C, "R9 key A reads status one");
        do_read(8'h70, "R9 key B reads status one");

        // R7 writes pass while open
        do_write(8'h64, 32'hCAFE_F00D, "R7 open scratch write qualifier");
        do_read(8'h64, "R7 R8 open scratch readback");
        do_write(8'h40, 32'h0000_0001, "R7 open unrelated write qualifier");

        // R4 wrong value closes
        do_write(8'h70, 32'h95A4_F1E1, "R4 wrong key B qualifier");
        check_open("R4 closed after wrong key B");
        do_write(8'h64, 32'h0BAD_0BAD, "R4 write after wrong key dropped");
        do_read(8'h64, "R4 scratch unchanged");

        // R2 reverse order (A still armed, rewrite both B then A)
        do_write(8'h6C, 32'h0000_0000, "R5 clear A");
        do_write(8'h70, 32'h95A4_F1E0, "R2 key B first");
        check_open("R3 only B keeps closed");
        do_write(8'h6C, 32'h83E7_0B13, "R2 key A second");
        check_open("R2 open after B then A");

        // R5 zero relock
        do_write(8'h6C, 32'h0, "R5 zero to key A");
        do_write(8'h70, 32'h0, "R5 zero to key B");
        check_open("R5 closed after zero writes");
        do_read(8'h70, "R9 key B reads status zero");
        do_read(8'h64, "R8 scratch readable while closed");

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            int sel;
            a = pool[$urandom_range(0, 5)];
            sel = $urandom_range(0, 3);
            if (sel == 0 || sel == 1) d = (a == 8'h70) ? 32'h95A4_F1E0 : 32'h83E7_0B13;
            else if (sel == 2) d = '0;
            else d = $urandom();
            if ($urandom_range(0, 1) == 0) do_write(a, d, "R6 R7 R10 random write qualifier");
            else do_read(a, "R8 R9 random read");
            if (n % 8 == 0) check_open("R2 R4 random open state");
        end

        finish_run();
    end
endmodule